// File: doc/BRIEF.md
# Predicated Vector Duplicate Execution Unit

This unit recognises one vector-duplicate instruction and carries it out. A 32-bit instruction word arrives with a valid strobe. The unit decodes the word in the same cycle and drives the index of the source general-purpose register onto a combinational read port. The register file answers in that cycle. The unit then replicates the low byte, the low halfword or the whole word of the value across a 128-bit vector. The lane size comes from two instruction bits that are not next to each other.

One cycle after it accepts the instruction, the unit presents a write-back: the destination vector index, the replicated data and a 16-bit byte-enable mask taken from the predicate. The register file performs the byte-wise merge. Bytes whose enable is clear keep their old value. Each write is paired with a one-cycle predicate-advance pulse. An instruction that matches but names a forbidden source register or an unimplemented destination does not write. It raises the illegal-instruction flag for one cycle instead. A word that does not match the encoding leaves every output idle, so another decoder can claim it.

The control is a three-state machine:
- ST_IDLE: no output is active.
- ST_WRITE: the write-back and the predicate advance are presented.
- ST_FAULT: the illegal flag is presented.

At every clock the next state is chosen from the current input, whatever the current state is:
- GO_WRITE: a valid, matching and legal instruction moves the machine to ST_WRITE.
- GO_FAULT: a valid and matching instruction with a forbidden operand moves it to ST_FAULT.
- GO_IDLE: any other input returns it to ST_IDLE.

Top module: `vdup_exec_unit`

## Requirements
- R1: A word is accepted only if bits 31:23 = 1110_1110_1, bits 21:20 = 10, bit 16 = 0, bits 11:8 = 1011, bit 6 = 0, bit 4 = 1 and bits 3:0 = 0000. A valid word that does not match leaves wb_valid, illegal_instr and pred_advance low in the next cycle, with wb_idx, wb_data and wb_byte_en at zero. While instr_valid is low, the unit accepts nothing.
- R2: When bit 22 = 1 and bit 5 = 0, the low byte of the source is repeated into all 16 bytes of wb_data.
- R3: When bit 22 = 0 and bit 5 = 1, the low halfword of the source is repeated into all 8 halfwords of wb_data.
- R4: When bit 22 = 0 and bit 5 = 0, the full 32-bit source is repeated into all four words of wb_data.
- R5: wb_idx is the destination index, built with bit 7 as its top bit and bits 19:17 as its low three bits.
- R6: gpr_rd_idx always equals bits 15:12 of instr_word, and it is combinational.
- R7: A matching word with source index 13 or 15 raises illegal_instr for one cycle, with wb_valid and pred_advance low.
- R8: A matching word with destination index 8 or above (bit 7 set, with the default bank of 8) raises illegal_instr, with no write and no advance.
- R9: wb_byte_en equals the pred_mask sampled with the instruction; bit i enables byte i (wb_data bits 8i+7:8i).
- R10: wb_valid, wb_data, wb_idx and wb_byte_en appear in the cycle after a valid instruction is accepted. pred_advance is high in exactly the cycles where wb_valid is high. Back-to-back instructions give back-to-back results.
- R11: After reset all outputs except gpr_rd_idx are zero.
- R12: A word with bit 22 = 1 and bit 5 = 1 does not match and is treated as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| pred_mask | input | 16 | Per-byte predicate for the destination |
| gpr_rd_idx | output | 4 | Source register index to the register file |
| gpr_rd_data | input | 32 | Source register value, same cycle |
| wb_valid | output | 1 | Vector write-back strobe |
| wb_idx | output | 3 | Destination vector register index |
| wb_data | output | 128 | Replicated result |
| wb_byte_en | output | 16 | Byte enables for the merge |
| illegal_instr | output | 1 | Illegal-instruction pulse |
| pred_advance | output | 1 | Predicate-step pulse |

## Verification
The bench builds the unit with its defaults: a 128-bit vector and a bank of eight registers. With these, bit 7 of the destination field always lands outside the bank, so every fault route can be reached. The replicated data splits into 16 byte enables, so patterns such as all-ones, all-zero and alternating enables can be compared byte by byte. The stimulus also covers all four combinations of the size bits, every source index including the two forbidden ones, and back-to-back words mixed with non-matching ones.

// File: rtl/vdup_pkg.sv
package vdup_pkg;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_H16 = 2'd1,
        LANE_W32 = 2'd2
    } lane_size_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_FAULT = 2'd2
    } wb_state_e;

    typedef struct packed {
        logic       hit;
        logic       fault;
        lane_size_e size;
        logic [3:0] vd;
        logic [3:0] rt;
    } vdup_dec_t;

    localparam logic [3:0] RT_FORBID_LO = 4'd13;
    localparam logic [3:0] RT_FORBID_HI = 4'd15;

endpackage

// File: rtl/vdup_decoder.sv
module vdup_decoder
    import vdup_pkg::*;
#(
    parameter int NUM_VREGS = 8
) (
    input  logic [31:0] word_i,
    output vdup_dec_t   dec_o
);
    logic fixed_ok;
    logic sel_b;
    logic sel_e;
    logic size_ok;

    always_comb begin
        fixed_ok = (word_i[31:23] == 9'b1110_1110_1)
                && (word_i[21:20] == 2'b10)
                && !word_i[16]
                && (word_i[11:8] == 4'b1011)
                && !word_i[6]
                && word_i[4]
                && (word_i[3:0] == 4'b0000);
        sel_b = word_i[22];
        sel_e = word_i[5];
        size_ok = 1'b1;
        dec_o.size = LANE_W32;
        unique case ({sel_b, sel_e})
            2'b10:   dec_o.size = LANE_B8;
            2'b01:   dec_o.size = LANE_H16;
            2'b00:   dec_o.size = LANE_W32;
            default: size_ok = 1'b0;
        endcase
        dec_o.hit   = fixed_ok && size_ok;
        dec_o.vd    = {word_i[7], word_i[19:17]};
        dec_o.rt    = word_i[15:12];
        dec_o.fault = dec_o.hit
                   && ((dec_o.rt == RT_FORBID_LO) || (dec_o.rt == RT_FORBID_HI)
                       || ({1'b0, dec_o.vd} >= 5'(NUM_VREGS)));
    end
endmodule

// File: rtl/vdup_replicator.sv
module vdup_replicator
    import vdup_pkg::*;
#(
    parameter int VLEN_BITS = 128
) (
    input  lane_size_e             size_i,
    input  logic [31:0]            src_i,
    output logic [VLEN_BITS-1:0]   vec_o
);
    localparam int WORDS = VLEN_BITS / 32;

    logic [31:0] word_pat;

    always_comb begin
        word_pat = src_i;
        unique case (size_i)
            LANE_B8:  word_pat = {4{src_i[7:0]}};
            LANE_H16: word_pat = {2{src_i[15:0]}};
            LANE_W32: word_pat = src_i;
            default:  word_pat = src_i;
        endcase
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign vec_o[w*32 +: 32] = word_pat;
    end
endmodule

// File: rtl/vdup_wb_ctrl.sv
module vdup_wb_ctrl
    import vdup_pkg::*;
#(
    parameter int VLEN_BITS = 128,
    parameter int IDX_W     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take_i,
    input  logic                   fault_i,
    input  logic [IDX_W-1:0]       idx_i,
    input  logic [VLEN_BITS-1:0]   vec_i,
    input  logic [VLEN_BITS/8-1:0] mask_i,
    output logic                   wb_valid_o,
    output logic [IDX_W-1:0]       wb_idx_o,
    output logic [VLEN_BITS-1:0]   wb_data_o,
    output logic [VLEN_BITS/8-1:0] wb_en_o,
    output logic                   illegal_o,
    output logic                   advance_o
);
    localparam int EN_W = VLEN_BITS / 8;

    wb_state_e state_q, state_d;
    logic [IDX_W-1:0]     idx_q;
    logic [VLEN_BITS-1:0] vec_q;
    logic [EN_W-1:0]      en_q;

    // Transition choice: GO_WRITE, GO_FAULT or GO_IDLE
    always_comb begin
        state_d = ST_IDLE;
        if (take_i) state_d = fault_i ? ST_FAULT : ST_WRITE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            vec_q   <= '0;
            en_q    <= '0;
        end else begin
            state_q <= state_d;
            if (take_i && !fault_i) begin
                idx_q <= idx_i;
                vec_q <= vec_i;
                en_q  <= mask_i;
            end
        end
    end

    always_comb begin
        wb_valid_o = 1'b0;
        wb_idx_o   = '0;
        wb_data_o  = '0;
        wb_en_o    = '0;
        illegal_o  = 1'b0;
        advance_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_WRITE: begin
                wb_valid_o = 1'b1;
                wb_idx_o   = idx_q;
                wb_data_o  = vec_q;
                wb_en_o    = en_q;
                advance_o  = 1'b1;
            end
            ST_FAULT: illegal_o = 1'b1;
            default: ;
        endcase
    end

    assert_fault_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wb_valid_o && !advance_o));
    assert_advance_pairs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> advance_o);
    assert_write_follows_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !fault_i |=> wb_valid_o);
    assert_one_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_valid_o, illegal_o}));
endmodule

// File: rtl/vdup_exec_unit.sv
module vdup_exec_unit
    import vdup_pkg::*;
#(
    parameter int VLEN_BITS = 128,
    parameter int NUM_VREGS = 8,
    localparam int IDX_W    = $clog2(NUM_VREGS),
    localparam int EN_W     = VLEN_BITS / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [31:0]          instr_word,
    input  logic [EN_W-1:0]      pred_mask,
    output logic [3:0]           gpr_rd_idx,
    input  logic [31:0]          gpr_rd_data,
    output logic                 wb_valid,
    output logic [IDX_W-1:0]     wb_idx,
    output logic [VLEN_BITS-1:0] wb_data,
    output logic [EN_W-1:0]      wb_byte_en,
    output logic                 illegal_instr,
    output logic                 pred_advance
);
    vdup_dec_t            dec;
    logic [VLEN_BITS-1:0] rep_vec;

    vdup_decoder #(.NUM_VREGS(NUM_VREGS)) u_dec (
        .word_i (instr_word),
        .dec_o  (dec)
    );

    assign gpr_rd_idx = dec.rt;

    vdup_replicator #(.VLEN_BITS(VLEN_BITS)) u_rep (
        .size_i (dec.size),
        .src_i  (gpr_rd_data),
        .vec_o  (rep_vec)
    );

    vdup_wb_ctrl #(.VLEN_BITS(VLEN_BITS), .IDX_W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (instr_valid && dec.hit),
        .fault_i    (dec.fault),
        .idx_i      (dec.vd[IDX_W-1:0]),
        .vec_i      (rep_vec),
        .mask_i     (pred_mask),
        .wb_valid_o (wb_valid),
        .wb_idx_o   (wb_idx),
        .wb_data_o  (wb_data),
        .wb_en_o    (wb_byte_en),
        .illegal_o  (illegal_instr),
        .advance_o  (pred_advance)
    );

    assert_words_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_data[31:0] == wb_data[VLEN_BITS-1 -: 32]));
    assert_mask_carried_R9: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && dec.hit && !dec.fault |=> (wb_byte_en == $past(pred_mask)));
    assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(instr_valid && dec.hit) |=> (!wb_valid && !illegal_instr && !pred_advance));
    assert_bad_src_faults_R7: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid && dec.hit && (instr_word[15:12] == 4'd13) |=> illegal_instr);
endmodule

// File: tb/vdup_exec_unit_test.sv
module vdup_exec_unit_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         instr_valid = 1'b0;
    logic [31:0]  instr_word = '0;
    logic [15:0]  pred_mask = '0;
    logic [3:0]   gpr_rd_idx;
    logic [31:0]  gpr_rd_data;
    logic         wb_valid;
    logic [2:0]   wb_idx;
    logic [127:0] wb_data;
    logic [15:0]  wb_byte_en;
    logic         illegal_instr;
    logic         pred_advance;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [31:0] gpr [16];

    always #10 clk = ~clk;

    vdup_exec_unit uut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .pred_mask(pred_mask), .gpr_rd_idx(gpr_rd_idx), .gpr_rd_data(gpr_rd_data),
        .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .wb_byte_en(wb_byte_en),
        .illegal_instr(illegal_instr), .pred_advance(pred_advance)
    );

    assign gpr_rd_data = gpr[gpr_rd_idx];

    function automatic logic [31:0] mk(bit b, bit e, logic [3:0] vd, logic [3:0] rt);
        return 32'hEEA0_0B10 | (32'(b) << 22) | (32'(e) << 5) | (32'(vd[3]) << 7)
             | (32'(vd[2:0]) << 17) | (32'(rt) << 12);
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one word for one clock; reference model decides outputs of next cycle.
    task automatic apply(string tag, logic v, logic [31:0] w, logic [15:0] m);
        bit match, bad;
        logic [3:0] vd, rt;
        logic [31:0] s;
        logic [127:0] ed;
        instr_valid = v; instr_word = w; pred_mask = m;
        #1;
        chk({tag, "/R6 rd_idx"}, 128'(gpr_rd_idx), 128'(w[15:12]));
        match = (w ==? 32'b1110_1110_1?10_???0_????_1011_?0?1_0000) && !(w[22] && w[5]);
        vd = {w[7], w[19:17]};
        rt = w[15:12];
        bad = (rt == 4'd13) || (rt == 4'd15) || (vd > 4'd7);
        s = gpr[rt];
        ed = '0;
        if (w[22]) begin
            for (int i = 0; i < 16; i++) ed[i*8 +: 8] = s[7:0];
        end else if (w[5]) begin
            for (int i = 0; i < 8; i++) ed[i*16 +: 16] = s[15:0];
        end else begin
            for (int i = 0; i < 4; i++) ed[i*32 +: 32] = s;
        end
        @(negedge clk);
        if (v && match && !bad) begin
            chk({tag, "/R10 wb_valid"}, 128'(wb_valid), 128'd1);
            chk({tag, "/R10 adv"}, 128'(pred_advance), 128'd1);
            chk({tag, "/R7 illegal"}, 128'(illegal_instr), 128'd0);
            chk({tag, "/R5 idx"}, 128'(wb_idx), 128'(vd[2:0]));
            chk({tag, "/R2 R3 R4 data"}, wb_data, ed);
            chk({tag, "/R9 en"}, 128'(wb_byte_en), 128'(m));
        end else if (v && match) begin
            chk({tag, "/R7 R8 illegal"}, 128'(illegal_instr), 128'd1);
            chk({tag, "/R7 R8 wb_valid"}, 128'(wb_valid), 128'd0);
            chk({tag, "/R7 R8 adv"}, 128'(pred_advance), 128'd0);
        end else begin
            chk({tag, "/R1 R12 flags"}, {125'd0, wb_valid, illegal_instr, pred_advance}, 128'd0);
            chk({tag, "/R1 data"}, wb_data, 128'd0);
            chk({tag, "/R1 en_idx"}, 128'({wb_byte_en, wb_idx}), 128'd0);
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) gpr[i] = 32'h9A3C_5E71 ^ (32'(i) * 32'h0111_0F2D);
        repeat (3) @(negedge clk);
        chk("R11 reset", {wb_data, 125'd0, wb_valid, illegal_instr, pred_advance} , '0);
        chk("R11 reset en", 128'({wb_byte_en, wb_idx}), 128'd0);
        rst_n = 1'b1;
        apply("byte", 1, mk(1, 0, 4'd3, 4'd2), 16'hFFFF);
        apply("half", 1, mk(0, 1, 4'd5, 4'd7), 16'hA5A5);
        apply("word", 1, mk(0, 0, 4'd7, 4'd14), 16'h0000);
        apply("word0", 1, mk(0, 0, 4'd0, 4'd0), 16'h00FF);
        apply("both", 1, mk(1, 1, 4'd1, 4'd1), 16'hFFFF);
        apply("rt13", 1, mk(1, 0, 4'd2, 4'd13), 16'hFFFF);
        apply("rt15", 1, mk(0, 0, 4'd2, 4'd15), 16'hFFFF);
        apply("vd9", 1, mk(0, 1, 4'd9, 4'd3), 16'hFFFF);
        apply("vd15", 1, mk(0, 0, 4'd15, 4'd4), 16'h1234);
        apply("bit16", 1, mk(0, 0, 4'd1, 4'd1) | 32'h0001_0000, 16'hFFFF);
        apply("bit6", 1, mk(0, 0, 4'd1, 4'd1) | 32'h0000_0040, 16'hFFFF);
        apply("bit0", 1, mk(0, 0, 4'd1, 4'd1) | 32'h0000_0001, 16'hFFFF);
        apply("novalid", 0, mk(1, 0, 4'd4, 4'd4), 16'hFFFF);
        apply("idle", 0, 32'h0, 16'h0);
        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            w = mk(1'($urandom), 1'($urandom), 4'($urandom), 4'($urandom));
            if ($urandom_range(0, 7) == 0) w = w ^ (32'd1 << $urandom_range(0, 31));
            apply("rand", 1'($urandom_range(0, 5) != 0), w, 16'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule